// File: doc/BRIEF.md
# SPI Command Controller Register and Interrupt Block

This block is the host-facing register file of a command-driven SPI controller. A 32-bit read/write port gives the host a soft-reset control, an interrupt enable mask, a pending register that is cleared by writing ones, a masked interrupt-source view, and the 8-bit identifier of the most recent sync event. It also gives access to the three FIFOs that sit outside the block. Command words and transmit words are pushed through write ports. Received words are popped through one read port, and a second read port returns the head entry without removing it.

The block is given the fill levels of the external FIFOs. From those levels it reports free room for the two outbound FIFOs and the fill level of the inbound FIFO. The same levels drive three watermark interrupt conditions. The execution core reports each completed sync command with a one-cycle strobe and its identifier. One interrupt line is raised while any enabled pending bit is set.

Top module: `spi_cmd_csr`

## Requirements
- R1: After reset the enable mask, the sync identifier and the soft-reset control read 0, `eng_rst` and `irq` are low, and the pending register reads 0 while no watermark or sync condition is present.
- R2: Pending bit 0 is set on the clock edge after `cmd_level <= CMD_AE`. Bit 1 is set on the edge after `tx_level <= TX_AE`. Bit 2 is set on the edge after `rx_level >= RX_AF`. Each bit is set again on every cycle its condition holds.
- R3: A write to 0x84 clears each pending bit whose data bit is 1 and leaves the other bits unchanged. A set condition in the same cycle wins over the clear.
- R4: A `sync_valid` strobe stores `sync_id` in the register at 0xC0 (bits 7:0) and sets pending bit 3. A strobe in the same cycle as a clear of bit 3 leaves bit 3 set.
- R5: Bits 3:0 at 0x80 hold the enable mask. Address 0x88 reads pending AND enable. `irq` is high exactly when that value is nonzero.
- R6: Bit 0 at 0x40 drives `eng_rst`. Writing 1 holds the engine in reset, writing 0 releases it, and writes to other addresses leave it unchanged.
- R7: Address 0xD0 reads `CMD_DEPTH - cmd_level`, 0xD4 reads `TX_DEPTH - tx_level`, and 0xD8 reads `rx_level`.
- R8: A write to 0xE0 raises `cmd_push` in the same cycle with `cmd_data` equal to the write data, bits CMD_W-1:0. A write to 0xE4 does the same on `tx_push`/`tx_data`. A write to a FIFO whose level equals its depth raises no push.
- R9: A read of 0xE8 with a nonempty receive FIFO raises `rx_pop` in the same cycle and returns `rx_head`. With an empty FIFO it raises no pop and returns 0.
- R10: A read of 0xEC returns `rx_head` without raising `rx_pop`, and returns 0 when the receive FIFO is empty.
- R11: Read data appears on `bus_rdata` on the edge after `bus_rd` and is held until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cmd_push | output | 1 | Push strobe to the command FIFO |
| cmd_data | output | CMD_W | Command word |
| cmd_level | input | clog2(CMD_DEPTH+1) | Command FIFO fill level |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | DATA_W | Transmit word |
| tx_level | input | clog2(TX_DEPTH+1) | Transmit FIFO fill level |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_head | input | DATA_W | Head entry of the receive FIFO |
| rx_level | input | clog2(RX_DEPTH+1) | Receive FIFO fill level |
| sync_valid | input | 1 | Sync command completed |
| sync_id | input | 8 | Identifier of that sync command |
| eng_rst | output | 1 | Soft reset to the execution core |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted pending or enable bit shows on `irq` in the same cycle, and on reads of 0x84 and 0x88 one cycle after the read strobe. A wrong room or watermark comparison shows when the levels are swept over every value from empty to full: both the room value and the pending bit are wrong at one or more levels. A push or pop strobe that ignores the full or empty condition shows combinationally in the cycle of the access. A lost sync identifier shows on the next read of 0xC0.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;
    localparam logic [7:0] A_RESET    = 8'h40;
    localparam logic [7:0] A_IEN      = 8'h80;
    localparam logic [7:0] A_IPEND    = 8'h84;
    localparam logic [7:0] A_ISRC     = 8'h88;
    localparam logic [7:0] A_SYNC     = 8'hC0;
    localparam logic [7:0] A_CMD_ROOM = 8'hD0;
    localparam logic [7:0] A_TX_ROOM  = 8'hD4;
    localparam logic [7:0] A_RX_LVL   = 8'hD8;
    localparam logic [7:0] A_CMD_PORT = 8'hE0;
    localparam logic [7:0] A_TX_PORT  = 8'hE4;
    localparam logic [7:0] A_RX_POP   = 8'hE8;
    localparam logic [7:0] A_RX_PEEK  = 8'hEC;

    localparam int NUM_IRQ  = 4;
    localparam int IRQ_CMD  = 0;
    localparam int IRQ_TX   = 1;
    localparam int IRQ_RX   = 2;
    localparam int IRQ_SYNC = 3;

    typedef logic [NUM_IRQ-1:0] irq_vec_t;

    typedef struct packed {
        irq_vec_t    en;
        irq_vec_t    pend;
        logic [7:0]  sid;
    } irq_state_t;

    typedef struct packed {
        logic        hold;
        logic [31:0] rdata;
    } top_state_t;
endpackage

// File: rtl/spi_csr_push_gate.sv
module spi_csr_push_gate #(
    parameter int DEPTH   = 16,
    parameter int DW      = 32,
    parameter int AE_MARK = 4,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    input  logic [LW-1:0] level,
    output logic          push,
    output logic [DW-1:0] data,
    output logic [LW-1:0] room,
    output logic          low_mark
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);
    localparam logic [LW-1:0] MARK = LW'(AE_MARK);

    always_comb begin
        push     = wr_hit && (level != FULL);
        data     = wdata;
        room     = FULL - level;
        low_mark = (level <= MARK);
    end

    // R8: a push never reaches a FIFO that reports itself full
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (level < FULL));
endmodule

// File: rtl/spi_csr_irq.sv
module spi_csr_irq
    import spi_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_wr,
    input  logic       pend_wr,
    input  irq_vec_t   wmask,
    input  logic       cmd_low,
    input  logic       tx_low,
    input  logic       rx_high,
    input  logic       sync_valid,
    input  logic [7:0] sync_id,
    output irq_vec_t   en_q,
    output irq_vec_t   pend_q,
    output logic [7:0] sid_q,
    output logic       irq
);
    irq_state_t st_d, st_q;
    irq_vec_t   set_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[IRQ_CMD]  = cmd_low;
        set_vec[IRQ_TX]   = tx_low;
        set_vec[IRQ_RX]   = rx_high;
        set_vec[IRQ_SYNC] = sync_valid;
        st_d = st_q;
        if (en_wr)      st_d.en   = wmask;
        if (pend_wr)    st_d.pend = st_q.pend & ~wmask;
        st_d.pend = st_d.pend | set_vec;
        if (sync_valid) st_d.sid  = sync_id;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign pend_q = st_q.pend;
    assign sid_q  = st_q.sid;
    assign irq    = |(st_q.pend & st_q.en);

    // R4: a sync strobe leaves its pending bit set and its identifier stored
    p_sync_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |=> pend_q[IRQ_SYNC]);
    p_sync_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |=> (sid_q == $past(sync_id)));
    // R3: a write of one clears the sync bit when no new sync arrives
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && wmask[IRQ_SYNC] && !sync_valid) |=> !pend_q[IRQ_SYNC]);
    // R2: the command watermark condition sets its bit on the next edge
    p_cmd_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_low |=> pend_q[IRQ_CMD]);
    // R5: the interrupt line needs both a pending and an enabled bit
    p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend_q != '0) && (en_q != '0)));
endmodule

// File: rtl/spi_cmd_csr.sv
module spi_cmd_csr
    import spi_csr_pkg::*;
#(
    parameter int CMD_DEPTH = 16,
    parameter int TX_DEPTH  = 16,
    parameter int RX_DEPTH  = 16,
    parameter int CMD_AE    = 4,
    parameter int TX_AE     = 4,
    parameter int RX_AF     = 12,
    parameter int CMD_W     = 16,
    parameter int DATA_W    = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [7:0]                     bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    output logic                           cmd_push,
    output logic [CMD_W-1:0]               cmd_data,
    input  logic [$clog2(CMD_DEPTH+1)-1:0] cmd_level,
    output logic                           tx_push,
    output logic [DATA_W-1:0]              tx_data,
    input  logic [$clog2(TX_DEPTH+1)-1:0]  tx_level,
    output logic                           rx_pop,
    input  logic [DATA_W-1:0]              rx_head,
    input  logic [$clog2(RX_DEPTH+1)-1:0]  rx_level,
    input  logic                           sync_valid,
    input  logic [7:0]                     sync_id,
    output logic                           eng_rst,
    output logic                           irq
);
    localparam int CMD_LW = $clog2(CMD_DEPTH + 1);
    localparam int TX_LW  = $clog2(TX_DEPTH + 1);
    localparam int RX_LW  = $clog2(RX_DEPTH + 1);
    localparam logic [RX_LW-1:0] RX_MARK = RX_LW'(RX_AF);

    top_state_t        st_d, st_q;
    logic [CMD_LW-1:0] cmd_room;
    logic [TX_LW-1:0]  tx_room;
    logic              cmd_low, tx_low, rx_high, rx_empty;
    irq_vec_t          en_q, pend_q;
    logic [7:0]        sid_q;
    logic [31:0]       rd_mux;

    spi_csr_push_gate #(.DEPTH(CMD_DEPTH), .DW(CMD_W), .AE_MARK(CMD_AE)) cmd_gate_i (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(bus_wr && (bus_addr == A_CMD_PORT)),
        .wdata(bus_wdata[CMD_W-1:0]), .level(cmd_level),
        .push(cmd_push), .data(cmd_data), .room(cmd_room), .low_mark(cmd_low)
    );

    spi_csr_push_gate #(.DEPTH(TX_DEPTH), .DW(DATA_W), .AE_MARK(TX_AE)) tx_gate_i (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(bus_wr && (bus_addr == A_TX_PORT)),
        .wdata(bus_wdata[DATA_W-1:0]), .level(tx_level),
        .push(tx_push), .data(tx_data), .room(tx_room), .low_mark(tx_low)
    );

    spi_csr_irq irq_i (
        .clk(clk), .rst_n(rst_n),
        .en_wr(bus_wr && (bus_addr == A_IEN)),
        .pend_wr(bus_wr && (bus_addr == A_IPEND)),
        .wmask(bus_wdata[NUM_IRQ-1:0]),
        .cmd_low(cmd_low), .tx_low(tx_low), .rx_high(rx_high),
        .sync_valid(sync_valid), .sync_id(sync_id),
        .en_q(en_q), .pend_q(pend_q), .sid_q(sid_q), .irq(irq)
    );

    always_comb begin
        rx_empty = (rx_level == '0);
        rx_high  = (rx_level >= RX_MARK);
        rx_pop   = bus_rd && (bus_addr == A_RX_POP) && !rx_empty;

        case (bus_addr)
            A_RESET:    rd_mux = 32'(st_q.hold);
            A_IEN:      rd_mux = 32'(en_q);
            A_IPEND:    rd_mux = 32'(pend_q);
            A_ISRC:     rd_mux = 32'(pend_q & en_q);
            A_SYNC:     rd_mux = 32'(sid_q);
            A_CMD_ROOM: rd_mux = 32'(cmd_room);
            A_TX_ROOM:  rd_mux = 32'(tx_room);
            A_RX_LVL:   rd_mux = 32'(rx_level);
            A_RX_POP,
            A_RX_PEEK:  rd_mux = rx_empty ? 32'd0 : 32'(rx_head);
            default:    rd_mux = 32'd0;
        endcase

        st_d = st_q;
        if (bus_wr && (bus_addr == A_RESET)) st_d.hold  = bus_wdata[0];
        if (bus_rd)                          st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign eng_rst   = st_q.hold;

    // R9: the receive FIFO is never popped while it reports empty
    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rx_level != '0));
    // R6: only a write to the reset register moves the engine reset
    p_rst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_RESET)) |=> $stable(eng_rst));
    // R11: read data holds between read strobes
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // R10: a peek never removes the head entry
    p_peek_no_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == A_RX_PEEK)) |-> !rx_pop);
endmodule

// File: tb/spi_cmd_csr_tb.sv
module spi_cmd_csr_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        cmd_push, tx_push, rx_pop;
    logic [15:0] cmd_data;
    logic [31:0] tx_data, rx_head;
    logic [4:0]  cmd_level, tx_level, rx_level;
    logic        sync_valid;
    logic [7:0]  sync_id;
    logic        eng_rst, irq;

    int checks = 0;
    int errors = 0;
    logic        seen_cmd_push, seen_tx_push, seen_pop;
    logic [15:0] seen_cmd_data;
    logic [31:0] seen_tx_data, rd_val;

    always #(CLK_P/2) clk = ~clk;

    spi_cmd_csr dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_push(cmd_push), .cmd_data(cmd_data), .cmd_level(cmd_level),
        .tx_push(tx_push), .tx_data(tx_data), .tx_level(tx_level),
        .rx_pop(rx_pop), .rx_head(rx_head), .rx_level(rx_level),
        .sync_valid(sync_valid), .sync_id(sync_id),
        .eng_rst(eng_rst), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        seen_cmd_push = cmd_push; seen_cmd_data = cmd_data;
        seen_tx_push  = tx_push;  seen_tx_data  = tx_data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        seen_pop = rx_pop;
        @(negedge clk);
        bus_rd = 1'b0;
        rd_val = bus_rdata;
    endtask

    task automatic pulse_sync(input logic [7:0] id);
        @(negedge clk);
        sync_valid = 1'b1; sync_id = id;
        @(negedge clk);
        sync_valid = 1'b0;
    endtask

    task automatic quiet_levels();
        @(negedge clk);
        cmd_level = 5'd10; tx_level = 5'd10; rx_level = 5'd0;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        cmd_level = 5'd10; tx_level = 5'd10; rx_level = 5'd0; rx_head = '0;
        sync_valid = 1'b0; sync_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 eng_rst", 32'(eng_rst), 0);
        rd(8'h80); check("R1 enable", rd_val, 0);
        rd(8'h84); check("R1 pending", rd_val, 0);
        rd(8'hC0); check("R1 sync id", rd_val, 0);
        rd(8'h40); check("R1 reset reg", rd_val, 0);

        // R7 and R2: sweep every level of each FIFO
        for (int l = 0; l <= 16; l++) begin
            @(negedge clk); cmd_level = 5'(l);
            wr(8'h84, 32'hF);
            rd(8'hD0); check("R7 cmd room", rd_val, 32'(16 - l));
            rd(8'h84); check("R2 cmd mark", rd_val, (l <= 4) ? 32'h1 : 32'h0);
        end
        quiet_levels();
        for (int l = 0; l <= 16; l++) begin
            @(negedge clk); tx_level = 5'(l);
            wr(8'h84, 32'hF);
            rd(8'hD4); check("R7 tx room", rd_val, 32'(16 - l));
            rd(8'h84); check("R2 tx mark", rd_val, (l <= 4) ? 32'h2 : 32'h0);
        end
        quiet_levels();
        for (int l = 0; l <= 16; l++) begin
            @(negedge clk); rx_level = 5'(l);
            wr(8'h84, 32'hF);
            rd(8'hD8); check("R7 rx level", rd_val, 32'(l));
            rd(8'h84); check("R2 rx mark", rd_val, (l >= 12) ? 32'h4 : 32'h0);
        end
        quiet_levels();
        wr(8'h84, 32'hF);

        // R3 write-one-to-clear
        @(negedge clk); cmd_level = 5'd2;
        @(negedge clk); cmd_level = 5'd10;
        wr(8'h84, 32'hE);
        rd(8'h84); check("R3 zero bits untouched", rd_val, 32'h1);
        wr(8'h84, 32'h1);
        rd(8'h84); check("R3 one clears", rd_val, 32'h0);
        @(negedge clk); cmd_level = 5'd0;
        wr(8'h84, 32'hFF);
        rd(8'h84); check("R3 set wins over clear", rd_val, 32'h1);
        quiet_levels();
        wr(8'h84, 32'hFF);
        rd(8'h84); check("R3 clear all", rd_val, 32'h0);

        // R4 sync identifier and pending bit
        foreach (sync_id_list[i]) begin
            pulse_sync(sync_id_list[i]);
            rd(8'hC0); check("R4 sync id", rd_val, 32'(sync_id_list[i]));
            rd(8'h84); check("R4 sync pending", rd_val, 32'h8);
            wr(8'h84, 32'h8);
            rd(8'h84); check("R4 sync cleared", rd_val, 32'h0);
        end
        @(negedge clk);
        sync_valid = 1'b1; sync_id = 8'h3C;
        bus_wr = 1'b1; bus_addr = 8'h84; bus_wdata = 32'h8;
        @(negedge clk);
        sync_valid = 1'b0; bus_wr = 1'b0;
        rd(8'h84); check("R4 sync beats clear", rd_val, 32'h8);
        rd(8'hC0); check("R4 sync id with clear", rd_val, 32'h3C);

        // R5 enable sweep against all-pending
        @(negedge clk); cmd_level = 5'd0; tx_level = 5'd0; rx_level = 5'd16;
        pulse_sync(8'h01);
        for (int e = 0; e < 16; e++) begin
            wr(8'h80, 32'(e));
            check("R5 irq", 32'(irq), (e != 0) ? 32'd1 : 32'd0);
            rd(8'h88); check("R5 source", rd_val, 32'(e));
            rd(8'h80); check("R5 enable readback", rd_val, 32'(e));
        end
        quiet_levels();
        wr(8'h84, 32'hF);
        check("R5 irq after clear", 32'(irq), 0);
        rd(8'h88); check("R5 source after clear", rd_val, 0);
        wr(8'h80, 32'h0);

        // R6 soft reset
        wr(8'h40, 32'h1);
        check("R6 hold", 32'(eng_rst), 1);
        rd(8'h40); check("R6 readback", rd_val, 1);
        wr(8'h80, 32'h0);
        check("R6 other write", 32'(eng_rst), 1);
        wr(8'h40, 32'h0);
        check("R6 release", 32'(eng_rst), 0);

        // R8 push ports, including full
        foreach (push_levels[i]) begin
            @(negedge clk); cmd_level = push_levels[i]; tx_level = push_levels[i];
            wr(8'hE0, 32'h1234_A5C3 + 32'(i));
            check("R8 cmd push", 32'(seen_cmd_push), (push_levels[i] < 16) ? 32'd1 : 32'd0);
            check("R8 cmd data", 32'(seen_cmd_data), 32'(16'hA5C3 + 16'(i)));
            check("R8 no tx push on cmd", 32'(seen_tx_push), 0);
            wr(8'hE4, 32'hCAFE_0000 + 32'(i));
            check("R8 tx push", 32'(seen_tx_push), (push_levels[i] < 16) ? 32'd1 : 32'd0);
            check("R8 tx data", seen_tx_data, 32'hCAFE_0000 + 32'(i));
        end
        quiet_levels();

        // R9 pop and R10 peek
        @(negedge clk); rx_level = 5'd3; rx_head = 32'hDEAD_BEEF;
        rd(8'hE8);
        check("R9 pop strobe", 32'(seen_pop), 1);
        check("R9 pop data", rd_val, 32'hDEAD_BEEF);
        rd(8'hEC);
        check("R10 peek no pop", 32'(seen_pop), 0);
        check("R10 peek data", rd_val, 32'hDEAD_BEEF);
        @(negedge clk); rx_level = 5'd0;
        rd(8'hE8);
        check("R9 empty no pop", 32'(seen_pop), 0);
        check("R9 empty data", rd_val, 0);
        rd(8'hEC);
        check("R10 empty peek", rd_val, 0);

        // R11 hold and unmapped
        wr(8'h80, 32'h5);
        rd(8'h80);
        repeat (3) @(negedge clk);
        check("R11 data held", bus_rdata, 32'h5);
        rd(8'h44); check("R11 unmapped", rd_val, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [7:0] sync_id_list [3] = '{8'h5C, 8'hA3, 8'hFF};
    logic [4:0] push_levels  [3] = '{5'd0, 5'd15, 5'd16};
endmodule